// File: doc/BRIEF.md
# Asynchronous SRAM Read Strobe Timer

This block turns single read requests into the strobe sequence an asynchronous static memory expects. For each read it drives a 24-bit address, an active-low chip enable and an active-low output enable. The two strobes have separate programmable timing. Each has a lead-in (setup), an active width (pulse) and a total span (cycle), all counted in clock periods. Neither strobe's timing is derived from the other's.

A read starts on the clock edge where a request is accepted. The requester holds `req_valid` with an address, and the block accepts it when `req_ready` is high. The memory's data byte is latched on the clock edge that ends the active window of one chosen strobe. A capture-select input picks that strobe, and the block does not compare the two waveforms to find which one ends first. The captured byte is returned with a one-clock `rsp_done` pulse.

A read lasts as long as the longer of the two strobe spans. A new request is taken on the last clock of the current read. So a strobe with zero setup and zero hold stays low without a break across back-to-back reads. An active width of zero is not a legal setting.

Top module: `sram_rd_timer`

## Requirements
- R1: After reset, `mem_cs_n` and `mem_re_n` are 1, `mem_addr` is 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: Phase k is the clock period that follows the k-th rising edge after the accept edge, so phase 0 comes right after the accept edge. `mem_cs_n` is 0 in exactly the phases k with chip-setup ≤ k < chip-setup + chip-pulse, and is 1 otherwise. The pulse setting of each strobe must be at least 1 whenever a request is accepted.
- R3: `mem_re_n` follows the same rule with the read-enable setup and pulse. Its waveform does not depend on the chip-select settings.
- R4: A read lasts L = max(Ecs, Ere) phases, where E = max(cycle, setup + pulse) for each strobe. `req_ready` is 0 in phases 0 to L-2 and is 1 in phase L-1 and while idle.
- R5: `mem_addr` loads `req_addr` on the accept edge and holds that value until the next accept edge.
- R6: `cfg_rd_mode` = 1 latches `mem_din` on the edge that ends phase re-setup + re-pulse - 1. `cfg_rd_mode` = 0 latches it on the edge that ends phase cs-setup + cs-pulse - 1.
- R7: `rsp_done` is 1 for one clock, in the phase right after the latching edge, and `rsp_data` then shows the latched byte. At all other times `rsp_done` is 0.
- R8: A strobe with setup 0 and cycle equal to pulse stays at 0 without a gap across reads that follow each other directly.
- R9: A cycle setting smaller than setup + pulse acts as if it were setup + pulse.
- R10: The timing and mode inputs are sampled on the accept edge. Changing them during a read has no effect on that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cs_setup | input | CNT_W | Chip-select lead-in, in clocks |
| cfg_cs_pulse | input | CNT_W | Chip-select active width, at least 1 |
| cfg_cs_cycle | input | CNT_W | Chip-select total span |
| cfg_re_setup | input | CNT_W | Read-enable lead-in, in clocks |
| cfg_re_pulse | input | CNT_W | Read-enable active width, at least 1 |
| cfg_re_cycle | input | CNT_W | Read-enable total span |
| cfg_rd_mode | input | 1 | Capture strobe: 1 read enable, 0 chip select |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Read address |
| req_ready | output | 1 | Request accepted on this edge when high with valid |
| rsp_done | output | 1 | One-clock pulse, read data valid |
| rsp_data | output | DATA_W | Latched read byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_re_n | output | 1 | Active-low read enable |
| mem_din | input | DATA_W | Memory data bus |

## Verification
A vector table runs single reads with zero and non-zero setups, one-clock reads, long holds and cycle settings below setup + pulse, in both capture modes. The bench drives a different data byte in every phase, so the returned byte shows exactly which edge latched it. Some vectors end the two strobes in different orders, and these separate mode-driven capture from "whichever strobe ends first". Directed cases cover the reset state and back-to-back reads with an unbroken chip select. A further case changes the settings in the middle of a read, which shows whether they are sampled only at acceptance.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;
   localparam int NUM_STB = 2;
   localparam int STB_CS  = 0;
   localparam int STB_RE  = 1;

   typedef enum logic {
      CAP_ON_CS = 1'b0,
      CAP_ON_RE = 1'b1
   } cap_sel_e;
endpackage

// File: rtl/sram_rd_strobe.sv
module sram_rd_strobe #(
   parameter int CNT_W = 6,
   parameter int LEN_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] setup_n,
   input  logic [CNT_W-1:0] pulse_n,
   input  logic [CNT_W-1:0] setup_q,
   input  logic [CNT_W-1:0] pulse_q,
   input  logic [CNT_W-1:0] cycle_q,
   input  logic             busy_nxt,
   input  logic [LEN_W-1:0] t_nxt,
   input  logic             busy_q,
   input  logic [LEN_W-1:0] t_q,
   output logic             strobe_n,
   output logic             last,
   output logic [LEN_W-1:0] eff_len
);
   logic [LEN_W-1:0] open_n, close_n, close_q;
   logic             on_nxt;

   always_comb begin
      open_n  = LEN_W'(setup_n);
      close_n = LEN_W'(setup_n) + LEN_W'(pulse_n);
      close_q = LEN_W'(setup_q) + LEN_W'(pulse_q);
      on_nxt  = busy_nxt && (t_nxt >= open_n) && (t_nxt < close_n);
      last    = busy_q && (t_q == close_q - LEN_W'(1));
      eff_len = (LEN_W'(cycle_q) > close_q) ? LEN_W'(cycle_q) : close_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_n <= 1'b1;
      else        strobe_n <= ~on_nxt;
   end

   // R2 and R3: a strobe is only ever driven low inside a read
   assert_strobe_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n |-> busy_q);
endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq #(
   parameter int LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] len,
   input  logic             req_valid,
   output logic             req_ready,
   output logic             accept,
   output logic             busy_q,
   output logic [LEN_W-1:0] t_q,
   output logic             busy_nxt,
   output logic [LEN_W-1:0] t_nxt
);
   logic end_q;

   always_comb begin
      end_q     = busy_q && (t_q == len - LEN_W'(1));
      req_ready = !busy_q || end_q;
      accept    = req_valid && req_ready;
      if (accept) begin
         busy_nxt = 1'b1;
         t_nxt    = '0;
      end else if (busy_q && !end_q) begin
         busy_nxt = 1'b1;
         t_nxt    = t_q + LEN_W'(1);
      end else begin
         busy_nxt = 1'b0;
         t_nxt    = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         t_q    <= '0;
      end else begin
         busy_q <= busy_nxt;
         t_q    <= t_nxt;
      end
   end

   assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (t_q < len));
endmodule

// File: rtl/sram_rd_timer.sv
module sram_rd_timer
   import sram_rd_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_cs_setup,
   input  logic [CNT_W-1:0]  cfg_cs_pulse,
   input  logic [CNT_W-1:0]  cfg_cs_cycle,
   input  logic [CNT_W-1:0]  cfg_re_setup,
   input  logic [CNT_W-1:0]  cfg_re_pulse,
   input  logic [CNT_W-1:0]  cfg_re_cycle,
   input  logic              cfg_rd_mode,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_re_n,
   input  logic [DATA_W-1:0] mem_din
);
   localparam int LEN_W = CNT_W + 1;

   if (ADDR_W < 1 || DATA_W < 1 || CNT_W < 1) begin : g_bad_param
      $error("sram_rd_timer: widths must be positive");
   end

   logic [CNT_W-1:0] set_in [NUM_STB];
   logic [CNT_W-1:0] pul_in [NUM_STB];
   logic [CNT_W-1:0] cyc_in [NUM_STB];
   logic [CNT_W-1:0] set_q  [NUM_STB];
   logic [CNT_W-1:0] pul_q  [NUM_STB];
   logic [CNT_W-1:0] cyc_q  [NUM_STB];
   logic [CNT_W-1:0] set_n  [NUM_STB];
   logic [CNT_W-1:0] pul_n  [NUM_STB];
   logic [LEN_W-1:0] eff    [NUM_STB];
   logic [NUM_STB-1:0] stb_n, last;
   cap_sel_e         mode_q;
   logic             accept, busy_q, busy_nxt, sample;
   logic [LEN_W-1:0] t_q, t_nxt, len;

   assign set_in[STB_CS] = cfg_cs_setup;
   assign pul_in[STB_CS] = cfg_cs_pulse;
   assign cyc_in[STB_CS] = cfg_cs_cycle;
   assign set_in[STB_RE] = cfg_re_setup;
   assign pul_in[STB_RE] = cfg_re_pulse;
   assign cyc_in[STB_RE] = cfg_re_cycle;

   always_comb begin
      for (int i = 0; i < NUM_STB; i++) begin
         set_n[i] = accept ? set_in[i] : set_q[i];
         pul_n[i] = accept ? pul_in[i] : pul_q[i];
      end
      len    = (eff[STB_CS] > eff[STB_RE]) ? eff[STB_CS] : eff[STB_RE];
      sample = (mode_q == CAP_ON_RE) ? last[STB_RE] : last[STB_CS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_STB; i++) begin
            set_q[i] <= '0;
            pul_q[i] <= CNT_W'(1);
            cyc_q[i] <= '0;
         end
         mode_q   <= CAP_ON_CS;
         mem_addr <= '0;
      end else if (accept) begin
         for (int i = 0; i < NUM_STB; i++) begin
            set_q[i] <= set_in[i];
            pul_q[i] <= pul_in[i];
            cyc_q[i] <= cyc_in[i];
         end
         mode_q   <= cap_sel_e'(cfg_rd_mode);
         mem_addr <= req_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done <= 1'b0;
         rsp_data <= '0;
      end else begin
         rsp_done <= sample;
         if (sample) rsp_data <= mem_din;
      end
   end

   sram_rd_seq #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .len(len), .req_valid(req_valid),
      .req_ready(req_ready), .accept(accept), .busy_q(busy_q), .t_q(t_q),
      .busy_nxt(busy_nxt), .t_nxt(t_nxt)
   );

   for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
      sram_rd_strobe #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stb (
         .clk(clk), .rst_n(rst_n),
         .setup_n(set_n[g]), .pulse_n(pul_n[g]),
         .setup_q(set_q[g]), .pulse_q(pul_q[g]), .cycle_q(cyc_q[g]),
         .busy_nxt(busy_nxt), .t_nxt(t_nxt), .busy_q(busy_q), .t_q(t_q),
         .strobe_n(stb_n[g]), .last(last[g]), .eff_len(eff[g])
      );
   end

   assign mem_cs_n = stb_n[STB_CS];
   assign mem_re_n = stb_n[STB_RE];

   assert_pulse_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (cfg_cs_pulse != '0 && cfg_re_pulse != '0));

   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(mem_addr));

   assert_done_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(busy_q));

   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !accept) |=> $stable(mode_q));
endmodule

// File: tb/sram_rd_timer_bench.sv
`timescale 1ns/1ps
module sram_rd_timer_bench;
   typedef struct packed {
      logic [5:0]  css, csp, csc, res, rep, rec;
      logic        mode;
      logic [23:0] addr;
   } vec_t;

   // cs setup/pulse/cycle, re setup/pulse/cycle, mode, address
   localparam vec_t VECS [8] = '{
      '{6'd0, 6'd4, 6'd4,  6'd1, 6'd2, 6'd4, 1'b1, 24'h00A5C3},
      '{6'd1, 6'd3, 6'd6,  6'd2, 6'd1, 6'd5, 1'b0, 24'hFFFFFF},
      '{6'd2, 6'd2, 6'd1,  6'd0, 6'd1, 6'd1, 1'b0, 24'h123456},
      '{6'd0, 6'd1, 6'd1,  6'd0, 6'd1, 6'd1, 1'b1, 24'h800001},
      '{6'd3, 6'd1, 6'd2,  6'd1, 6'd5, 6'd9, 1'b1, 24'h0F0F0F},
      '{6'd2, 6'd5, 6'd10, 6'd4, 6'd2, 6'd3, 1'b0, 24'h7E57AB},
      '{6'd0, 6'd2, 6'd7,  6'd0, 6'd2, 6'd2, 1'b1, 24'h000001},
      '{6'd5, 6'd1, 6'd6,  6'd5, 6'd1, 6'd6, 1'b0, 24'h3C3C3C}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cfg_cs_setup = '0, cfg_cs_pulse = 6'd1, cfg_cs_cycle = '0;
   logic [5:0]  cfg_re_setup = '0, cfg_re_pulse = 6'd1, cfg_re_cycle = '0;
   logic        cfg_rd_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_ready, rsp_done, mem_cs_n, mem_re_n;
   logic [7:0]  rsp_data, mem_din = '0;
   logic [23:0] mem_addr;
   logic [7:0]  din_hist [64];
   int          n_chk = 0, n_bad = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   sram_rd_timer u_sram_rd_timer (
      .clk(clk), .rst_n(rst_n),
      .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse), .cfg_cs_cycle(cfg_cs_cycle),
      .cfg_re_setup(cfg_re_setup), .cfg_re_pulse(cfg_re_pulse), .cfg_re_cycle(cfg_re_cycle),
      .cfg_rd_mode(cfg_rd_mode), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n), .mem_din(mem_din)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int effc(input int s, input int p, input int c);
      return (c > s + p) ? c : s + p;
   endfunction

   task automatic run_read(input vec_t v, input bit scr, input int vid);
      int   css, csp, res, rep, len, sp, w;
      bit   short_cyc;
      logic e_cs, e_re, e_rdy, e_done;
      string t_cs, t_re, t_rdy;
      css = int'(v.css); csp = int'(v.csp);
      res = int'(v.res); rep = int'(v.rep);
      len = effc(css, csp, int'(v.csc));
      if (effc(res, rep, int'(v.rec)) > len) len = effc(res, rep, int'(v.rec));
      sp = v.mode ? res + rep : css + csp;
      short_cyc = (int'(v.csc) < css + csp) || (int'(v.rec) < res + rep);
      t_cs  = scr ? "R10" : "R2";
      t_re  = scr ? "R10" : "R3";
      t_rdy = short_cyc ? "R9" : "R4";
      w = 0;
      while (!req_ready && w < 100) begin step(); w++; end
      cfg_cs_setup = v.css; cfg_cs_pulse = v.csp; cfg_cs_cycle = v.csc;
      cfg_re_setup = v.res; cfg_re_pulse = v.rep; cfg_re_cycle = v.rec;
      cfg_rd_mode  = v.mode;
      req_valid = 1'b1;
      req_addr  = v.addr;
      step();
      req_valid = 1'b0;
      if (scr) begin
         // R10: settings change mid-read; the current read must not follow them
         cfg_cs_setup = 6'd0; cfg_cs_pulse = 6'd1; cfg_cs_cycle = 6'd1;
         cfg_re_setup = 6'd0; cfg_re_pulse = 6'd1; cfg_re_cycle = 6'd1;
         cfg_rd_mode  = ~v.mode;
      end
      for (int k = 0; k <= len + 1; k++) begin
         e_cs   = !(k >= css && k < css + csp);
         e_re   = !(k >= res && k < res + rep);
         e_rdy  = (k >= len - 1);
         e_done = (k == sp);
         chk(mem_cs_n === e_cs, t_cs, 32'(mem_cs_n), 32'(e_cs));
         chk(mem_re_n === e_re, t_re, 32'(mem_re_n), 32'(e_re));
         chk(req_ready === e_rdy, t_rdy, 32'(req_ready), 32'(e_rdy));
         chk(mem_addr === v.addr, "R5", 32'(mem_addr), 32'(v.addr));
         chk(rsp_done === e_done, "R7", 32'(rsp_done), 32'(e_done));
         if (k == sp)
            chk(rsp_data === din_hist[sp-1], "R6", 32'(rsp_data), 32'(din_hist[sp-1]));
         mem_din = 8'(vid * 37 + k * 11 + 3);
         din_hist[k] = mem_din;
         step();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R4 watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] a1, a2;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk(mem_cs_n === 1'b1, "R1", 32'(mem_cs_n), 32'd1);
      chk(mem_re_n === 1'b1, "R1", 32'(mem_re_n), 32'd1);
      chk(mem_addr === 24'd0, "R1", 32'(mem_addr), 32'd0);
      chk(req_ready === 1'b1, "R1", 32'(req_ready), 32'd1);
      chk(rsp_done === 1'b0, "R1", 32'(rsp_done), 32'd0);

      // vector table: R2 R3 R4 R5 R6 R7 R9
      for (int i = 0; i < 8; i++) run_read(VECS[i], 1'b0, i);

      // R10: mid-read settings change
      run_read(VECS[4], 1'b1, 20);
      run_read(VECS[5], 1'b1, 21);

      // R8: back-to-back reads, chip select setup 0, cycle == pulse (L = 3)
      a1 = 24'hABCDEF;
      a2 = 24'h135790;
      cfg_cs_setup = 6'd0; cfg_cs_pulse = 6'd3; cfg_cs_cycle = 6'd3;
      cfg_re_setup = 6'd1; cfg_re_pulse = 6'd1; cfg_re_cycle = 6'd3;
      cfg_rd_mode  = 1'b0;
      req_valid = 1'b1;
      req_addr  = a1;
      step();
      req_addr = a2;
      for (int k = 0; k < 6; k++) begin
         if (k == 3) req_valid = 1'b0;
         chk(mem_cs_n === 1'b0, "R8", 32'(mem_cs_n), 32'd0);
         chk(mem_re_n === ((k % 3) != 1), "R3", 32'(mem_re_n), 32'((k % 3) != 1));
         chk(mem_addr === ((k < 3) ? a1 : a2), "R5", 32'(mem_addr), 32'((k < 3) ? a1 : a2));
         step();
      end
      chk(mem_cs_n === 1'b1, "R8", 32'(mem_cs_n), 32'd1);
      chk(req_ready === 1'b1, "R4", 32'(req_ready), 32'd1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule